// File: doc/BRIEF.md
# Interrupt Controller with Read-to-Mask Lock

This block gathers up to 26 interrupt sources into a single interrupt request line. Each source is captured into a pending bit. A source marked as edge type sets its bit on a low-to-high transition. A source marked as level type sets its bit on every cycle it is high. A per-source enable mask selects which pending bits may raise the request.

A global enable bit qualifies the request. It behaves as a lock that software can take and release without a read-modify-write sequence. Reading the bit returns its current value and clears it in the same access, so one load both disables interrupts and tells software whether they were enabled. Writing 1 sets it again. Writing 0 has no effect.

The register interface is synchronous. A select code, a read strobe and a write strobe address three registers: pending, mask and global enable. Read data is combinational from the current state during the read cycle. Vectoring, priority encoding and the processor side are outside this block.

Top module: `irq_lock_ctrl`

## Requirements
- R1: After reset the global enable is 1, the mask and pending registers are all zero, and the interrupt output is 0.
- R2: An edge-type source sets its pending bit on the clock after it goes from 0 to 1. The bit stays set after the source falls. A source held high does not set the bit again once it has been cleared.
- R3: A level-type source (the bits set in parameter LEVEL_SRC; by default only bit 9) sets its pending bit on every clock in which it is high. Clearing the bit while the source is still high has no lasting effect.
- R4: A write to the pending register (select 0) clears each bit whose data bit is 0 and keeps each bit whose data bit is 1. A source set event in the same cycle wins over a clear.
- R5: A write to the mask register (select 1) loads all NSRC bits. A read of select 1 returns them.
- R6: The interrupt output is 1 exactly when the global enable is 1 and at least one bit is set in both the pending and the mask registers.
- R7: A read of the global enable (select 2) returns its value before the read in data bit 0, with all other data bits 0, and clears it on that clock.
- R8: A write to select 2 with data bit 0 equal to 1 sets the global enable. A write with data bit 0 equal to 0 leaves it unchanged.
- R9: When a read and a write of 1 to select 2 happen in the same cycle, the read returns the prior value and the global enable ends at 1.
- R10: Select 3 reads as zero. Writes to select 3 change no register.
- R11: The source bit positions are fixed: bit 0 is vertical blank, bit 3 is DMA, bits 4, 5 and 6 are timers 0 to 2, bit 9 is the sound core, bits 14, 15 and 16 are timers 3 to 5, and bit 25 is the highest source (NSRC = 26).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Interrupt source lines |
| sel_i | input | 2 | Register select: 0 pending, 1 mask, 2 global enable, 3 unused |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data, valid in the cycle of rd_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- the lock rules: a read clears the enable, a write of 1 sets it, and a write of 0 keeps it;
- that an edge event is always latched into pending;
- that a pending bit survives any write that does not clear it;
- the mask load;
- that select 3 has no effect on any register.

Some behaviours can only be shown by the bench scenarios:
- the value a read reports;
- the lasting re-set of a level source against a clear, and the absence of a re-set for an edge source held high;
- the fixed source positions, shown by sweeping a pulse across every bit;
- the request qualified by each mask bit in turn.

// File: rtl/irq_lock_ctrl.sv
module irq_lock_ctrl #(
  parameter int NSRC = 26,
  parameter logic [NSRC-1:0] LEVEL_SRC = {{(NSRC-10){1'b0}}, 1'b1, 9'b0}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [1:0]      sel_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);
  localparam logic [1:0] SEL_PEND = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_LOCK = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  logic [NSRC-1:0] src_q, pend, mask, set_v, edge_v;
  logic            gie;
  logic            pend_wr, mask_wr, lock_take, lock_give;

  assign pend_wr   = wr_i && (sel_i == SEL_PEND);
  assign mask_wr   = wr_i && (sel_i == SEL_MASK);
  assign lock_take = rd_i && (sel_i == SEL_LOCK);
  assign lock_give = wr_i && (sel_i == SEL_LOCK) && wdata_i[0];

  assign edge_v = src_i & ~src_q & ~LEVEL_SRC;
  assign set_v  = edge_v | (src_i & LEVEL_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pend  <= '0;
      mask  <= '0;
      gie   <= 1'b1;
    end else begin
      src_q <= src_i;
      pend  <= (pend_wr ? (pend & wdata_i) : pend) | set_v;
      if (mask_wr)        mask <= wdata_i;
      if (lock_give)      gie  <= 1'b1;
      else if (lock_take) gie  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel_i)
        SEL_PEND: rdata_o = pend;
        SEL_MASK: rdata_o = mask;
        SEL_LOCK: rdata_o[0] = gie;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = gie & (|(pend & mask));

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_take && !lock_give) |=> !gie); // R7
  AST_GIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_give |=> gie); // R9
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == SEL_LOCK && !wdata_i[0] && !rd_i) |=> gie == $past(gie)); // R8
  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(edge_v)) == $past(edge_v))); // R2
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & (pend_wr ? wdata_i : '1)))
              == $past(pend & (pend_wr ? wdata_i : '1)))); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask == $past(wdata_i)); // R5
  AST_SEL3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !rd_i && sel_i == SEL_NONE) |=> ($stable(mask) && $stable(gie))); // R10
endmodule

// File: tb/sim_irq_lock_ctrl.sv
`timescale 1ns/1ps
module sim_irq_lock_ctrl;
  localparam int N = 26;
  localparam real CLK = 8.0;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_i = '0, wdata_i = '0;
  logic [1:0] sel_i = '0;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [N-1:0] rdata_o;
  logic irq_o;
  int total = 0, bad = 0;
  logic [N-1:0] got;

  always #(CLK/2) clk = ~clk;

  irq_lock_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .sel_i(sel_i),
    .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(input logic [1:0] s, output logic [N-1:0] d);
    sel_i = s; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
    sel_i = s; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rw(input logic [1:0] s, input logic [N-1:0] d, output logic [N-1:0] q);
    sel_i = s; wdata_i = d; wr_i = 1'b1; rd_i = 1'b1; #1 q = rdata_o;
    @(negedge clk); wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic pulse(input int i);
    src_i[i] = 1'b1; tick(); src_i[i] = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("R1 irq after reset", irq_o, 0);
    rd(2'd0, got); chk("R1 pending after reset", got, 0);
    rd(2'd1, got); chk("R1 mask after reset", got, 0);
    rd(2'd2, got); chk("R1 enable after reset", got, 1);
    wr(2'd2, 1);

    // R2 R3 R11: pulse sweep over every source position
    for (int i = 0; i < N; i++) begin
      pulse(i);
      rd(2'd0, got);
      chk(i == 9 ? "R3 R11 level pulse latched" : "R2 R11 edge pulse latched",
          got, 32'(1) << i);
      wr(2'd0, '0);
      rd(2'd0, got); chk("R4 clear by zero", got, 0);
    end

    src_i[4] = 1'b1; src_i[9] = 1'b1; tick();
    wr(2'd0, '0);
    rd(2'd0, got); chk("R2 R3 held edge not reset, level re-set", got, 32'(1) << 9);
    src_i = '0; tick(); wr(2'd0, '0);
    rd(2'd0, got); chk("R3 level cleared after release", got, 0);

    pulse(0); pulse(3);
    wr(2'd0, ALL & ~(N'(1) << 3));
    rd(2'd0, got); chk("R4 write one keeps, zero clears", got, 1);
    wr(2'd0, '0);

    src_i[5] = 1'b1; wr(2'd0, '0); src_i[5] = 1'b0;
    rd(2'd0, got); chk("R4 set wins over clear", got, 32'(1) << 5);
    wr(2'd0, '0);

    begin
      logic [N-1:0] pats [4];
      pats[0] = ALL; pats[1] = {13{2'b10}}; pats[2] = {13{2'b01}}; pats[3] = '0;
      for (int k = 0; k < 4; k++) begin
        wr(2'd1, pats[k]); rd(2'd1, got); chk("R5 mask readback", got, pats[k]);
      end
    end

    for (int i = 0; i < N; i++) begin
      pulse(i);
      wr(2'd1, N'(1) << i); chk("R6 matching mask raises irq", irq_o, 1);
      wr(2'd1, ALL & ~(N'(1) << i)); chk("R6 other mask bits keep irq low", irq_o, 0);
      wr(2'd1, N'(1) << i); wr(2'd0, '0); chk("R6 cleared pending drops irq", irq_o, 0);
    end

    pulse(0); wr(2'd1, 1);
    chk("R6 irq with enable", irq_o, 1);
    wr(2'd2, '0); chk("R8 write zero keeps enable set", irq_o, 1);
    rd(2'd2, got); chk("R7 read returns prior 1", got, 1);
    chk("R7 read disables irq", irq_o, 0);
    rd(2'd2, got); chk("R7 second read returns 0", got, 0);
    wr(2'd2, '0); chk("R8 write zero keeps enable clear", irq_o, 0);
    wr(2'd2, 1); chk("R8 write one re-enables", irq_o, 1);

    rd(2'd2, got);
    rw(2'd2, 1, got); chk("R9 simultaneous returns prior 0", got, 0);
    chk("R9 write wins, irq back", irq_o, 1);
    rw(2'd2, 1, got); chk("R9 simultaneous returns prior 1", got, 1);
    chk("R9 enable remains set", irq_o, 1);

    wr(2'd3, ALL);
    rd(2'd3, got); chk("R10 select 3 reads zero", got, 0);
    rd(2'd1, got); chk("R10 mask untouched", got, 1);
    rd(2'd0, got); chk("R10 pending untouched", got, 1);
    chk("R10 irq untouched", irq_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule